// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Generator

This block produces the modulation term for a fractional-N PLL that runs with spread spectrum. Each reference-clock cycle it emits a non-negative offset that the downstream sigma-delta stage adds to the feedback divider. Over one modulation period the offset traces a triangle. It climbs one level per cycle during the first half of the period and falls one level per cycle during the second half. A phase flag marks the falling half.

The length of the period is given in clock cycles. In display use it is set to the number of pixels per line, so the profile repeats exactly once per line. A line-sync input restarts the profile on its rising edge, which keeps it aligned to every line. The peak level is the amplitude setting minus half the period count, clipped at zero. The offset is that level multiplied by a step-scaling value. New settings are taken only at a period boundary, at a sync restart, or while the generator is idle. This means a running triangle is never bent mid-way.

Top module: `ss_triangle_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `offset_o` is 0 and `phase_o` is 0.
- R2: When `mod_en_n` is 1 at a clock edge, `offset_o` is 0 and `phase_o` is 0 after that edge. Modulation runs only while `mod_en_n` is 0.
- R3: The profile repeats every 2*floor(P/2) cycles, where P is the period count. An odd P is treated as P-1.
- R4: A period count of 0 or 1 keeps the generator idle, with `offset_o` 0.
- R5: The level starts a period at 0 and rises by exactly one per cycle during the first floor(P/2) cycles. During the remaining cycles it falls by one per cycle and does not go below 0.
- R6: The level never exceeds the peak max(A - floor(P/2), 0), where A is the amplitude. Once the level reaches the peak, it holds there for the rest of the rising half.
- R7: `phase_o` is 1 exactly in the cycles of the falling half (position in period >= floor(P/2)) while running, and 0 otherwise.
- R8: A change of period, amplitude or step while running takes effect only at the start of the next period.
- R9: A rising edge of `line_sync_i` restarts the profile at position 0 and level 0, and loads the current settings.
- R10: `offset_o` equals level × step as a two's-complement value of width AMP_W+STEP_W+1 with bit 24 (the sign) always 0.
- R11: The level is 0 at the start of every period, so each triangle closes back to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| mod_en_n | input | 1 | Modulation enable, active low |
| period_i | input | 11 | Cycles in one modulation period |
| step_i | input | 13 | Offset units per level |
| amp_i | input | 11 | Amplitude setting; peak level is amp_i minus half the period |
| line_sync_i | input | 1 | Line sync; its rising edge restarts the profile |
| offset_o | output | 25 | Signed divider offset |
| phase_o | output | 1 | 1 during the falling half |

## Verification
The bench builds the block with its default widths: an 11-bit period, a 13-bit step and an 11-bit amplitude, with the unregistered output stage. These defaults make the largest even period of 2046 cycles reachable, with a peak near 1023 and a full-scale step of 8191. The largest offset, about 8.4 million, therefore exercises the top product bits. Small periods with large amplitudes exercise the case where the half-period limit bounds the level. Large periods with small amplitudes exercise the clip at the peak. Odd periods, periods below two, mid-period setting changes and sync pulses all fall within the same run.

// File: rtl/ss_triangle_pkg.sv
// Package: shared types for the triangular spread-spectrum generator.
package ss_triangle_pkg;
    // Half of the modulation period the profile is currently in.
    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } ss_phase_e;
endpackage

// File: rtl/ss_sync_edge.sv
// Module: ss_sync_edge
// Detects a rising edge on the line-sync input.
// Assumes: sync_i is already synchronous to clk_i.
module ss_sync_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    output logic rise_o
);
    logic sync_q;

    // Remember the previous sync level.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= sync_i;
    end

    assign rise_o = sync_i & ~sync_q;
endmodule

// File: rtl/ss_profile_seq.sv
// Module: ss_profile_seq
// Steps the position within the modulation period and the triangle level.
// It holds shadow copies of the settings, which are reloaded only at a
// restart point.
// Assumes: settings are static for at least one cycle around a restart.
module ss_profile_seq
    import ss_triangle_pkg::*;
#(
    parameter int PER_W  = 11,
    parameter int AMP_W  = 11,
    parameter int STEP_W = 13
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_ni,
    input  logic              sync_rise_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [AMP_W-1:0]  amp_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [AMP_W-1:0]  level_o,
    output logic [STEP_W-1:0] step_o,
    output ss_phase_e         phase_o,
    output logic              active_o
);
    localparam int HALF_W = PER_W - 1;
    localparam int CMP_W  = ((AMP_W > HALF_W) ? AMP_W : HALF_W) + 1;

    logic              act_q;
    logic [PER_W-1:0]  pos_q;
    logic [AMP_W-1:0]  lvl_q, lvl_nxt, peak_q, peak_in;
    logic [HALF_W-1:0] half_q, half_in;
    logic [STEP_W-1:0] step_q;
    logic [PER_W-1:0]  last_pos;
    logic [CMP_W-1:0]  amp_x, half_x;
    logic              reload, go, rising;

    // Derive the half period and the clipped peak from the live settings.
    always_comb begin
        half_in = period_i[PER_W-1:1];
        amp_x   = CMP_W'(amp_i);
        half_x  = CMP_W'(half_in);
        peak_in = (amp_x > half_x) ? AMP_W'(amp_x - half_x) : '0;
        go      = ~en_ni && (half_in != '0);
    end

    // Decide on a restart, and compute the next triangle level.
    always_comb begin
        last_pos = {half_q, 1'b0} - PER_W'(1);
        reload   = ~act_q | sync_rise_i | en_ni | (pos_q == last_pos);
        rising   = pos_q < PER_W'(half_q);
        if (rising) lvl_nxt = (lvl_q < peak_q) ? lvl_q + AMP_W'(1) : peak_q;
        else        lvl_nxt = (lvl_q != '0) ? lvl_q - AMP_W'(1) : '0;
    end

    // Hold the sequencer state, reloading settings at each restart point.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_q  <= 1'b0;
            pos_q  <= '0;
            lvl_q  <= '0;
            half_q <= '0;
            peak_q <= '0;
            step_q <= '0;
        end else if (reload) begin
            act_q  <= go;
            pos_q  <= '0;
            lvl_q  <= '0;
            half_q <= half_in;
            peak_q <= peak_in;
            step_q <= step_i;
        end else begin
            pos_q  <= pos_q + PER_W'(1);
            lvl_q  <= lvl_nxt;
        end
    end

    assign level_o  = lvl_q;
    assign step_o   = step_q;
    assign active_o = act_q;
    assign phase_o  = (act_q && !rising) ? PH_FALL : PH_RISE;

    // R6: the level stays within the clipped peak.
    assert_level_within_peak_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl_q <= peak_q);
    // R3: the position stays inside the period while running.
    assert_pos_in_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_q |-> (pos_q < {half_q, 1'b0}));
    // R9: a sync edge puts the profile back at its start.
    assert_restart_on_sync_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_rise_i |=> (pos_q == '0 && lvl_q == '0));
    // R5: the level moves by at most one per cycle while running.
    assert_single_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_q && !reload) |=> ((lvl_q == $past(lvl_q)) ||
                                (lvl_q == $past(lvl_q) + AMP_W'(1)) ||
                                (lvl_q + AMP_W'(1) == $past(lvl_q))));
endmodule

// File: rtl/ss_offset_scale.sv
// Module: ss_offset_scale
// Multiplies the triangle level by the step value, and signs the result.
// Assumes: the level and the step are unsigned. A parameter selects
// between a combinational and a registered output.
module ss_offset_scale #(
    parameter int AMP_W   = 11,
    parameter int STEP_W  = 13,
    parameter bit REG_OUT = 1'b0
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [AMP_W-1:0]              level_i,
    input  logic [STEP_W-1:0]             step_i,
    output logic signed [AMP_W+STEP_W:0]  offset_o
);
    localparam int PROD_W = AMP_W + STEP_W;
    logic [PROD_W-1:0] prod;

    assign prod = PROD_W'(level_i) * PROD_W'(step_i);

    generate
        if (REG_OUT) begin : g_reg
            logic signed [PROD_W:0] ofs_q;
            // Register the scaled offset.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) ofs_q <= '0;
                else         ofs_q <= $signed({1'b0, prod});
            end
            assign offset_o = ofs_q;
        end else begin : g_comb
            assign offset_o = $signed({1'b0, prod});
        end
    endgenerate
endmodule

// File: rtl/ss_triangle_gen.sv
// Module: ss_triangle_gen
// Top module: emits a triangular spread-spectrum offset and a phase flag
// each reference cycle.
// Assumes: all inputs are synchronous to clk_i.
module ss_triangle_gen
    import ss_triangle_pkg::*;
#(
    parameter int PER_W   = 11,
    parameter int STEP_W  = 13,
    parameter int AMP_W   = 11,
    parameter bit REG_OUT = 1'b0,
    localparam int OFS_W  = AMP_W + STEP_W + 1
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    mod_en_n,
    input  logic [PER_W-1:0]        period_i,
    input  logic [STEP_W-1:0]       step_i,
    input  logic [AMP_W-1:0]        amp_i,
    input  logic                    line_sync_i,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    phase_o
);
    logic              sync_rise, active;
    logic [AMP_W-1:0]  level;
    logic [STEP_W-1:0] step_sh;
    ss_phase_e         phase;

    ss_sync_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (line_sync_i),
        .rise_o (sync_rise)
    );

    ss_profile_seq #(.PER_W(PER_W), .AMP_W(AMP_W), .STEP_W(STEP_W)) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_ni       (mod_en_n),
        .sync_rise_i (sync_rise),
        .period_i    (period_i),
        .amp_i       (amp_i),
        .step_i      (step_i),
        .level_o     (level),
        .step_o      (step_sh),
        .phase_o     (phase),
        .active_o    (active)
    );

    ss_offset_scale #(.AMP_W(AMP_W), .STEP_W(STEP_W), .REG_OUT(REG_OUT)) u_scale (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .level_i  (level),
        .step_i   (step_sh),
        .offset_o (offset_o)
    );

    assign phase_o = (phase == PH_FALL);

    // R2: a disabled generator drives a zero offset after the edge.
    assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mod_en_n |=> (offset_o == '0 && !phase_o));
    // R4: a period count below two never starts the profile.
    assert_short_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_i < PER_W'(2) && !active) |=> !active);
    // R7: the phase flag is raised only while the generator runs.
    assert_phase_when_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o |-> active);
endmodule

// File: tb/tb_ss_triangle_gen.sv
// Bench: a behavioural reference model, compared with the outputs every cycle.
module tb_ss_triangle_gen;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               en_n = 1'b1;
    logic [10:0]        period = '0;
    logic [12:0]        step = '0;
    logic [10:0]        amp = '0;
    logic               sync = 1'b0;
    logic signed [24:0] offset;
    logic               phase;

    int    vectors = 0;
    int    errors  = 0;
    int    cycles  = 0;
    bit    done    = 1'b0;
    string tag     = "R1";

    // Reference model state.
    int m_act, m_pos, m_lvl, m_half, m_peak, m_step, m_sd;

    ss_triangle_gen dut (
        .clk_i(clk), .rst_ni(rst_n), .mod_en_n(en_n), .period_i(period),
        .step_i(step), .amp_i(amp), .line_sync_i(sync),
        .offset_o(offset), .phase_o(phase)
    );

    always #5 clk = ~clk;

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        int h;
        bit rise;
        h    = int'(period) / 2;
        rise = sync && (m_sd == 0);
        if (!rst_n) begin
            m_act = 0; m_pos = 0; m_lvl = 0; m_half = 0; m_peak = 0; m_step = 0; m_sd = 0;
        end else begin
            m_sd = sync;
            if (m_act == 0 || rise || en_n || m_pos == 2 * m_half - 1) begin
                m_half = h;
                m_peak = (int'(amp) > h) ? int'(amp) - h : 0;
                m_step = int'(step);
                m_pos  = 0;
                m_lvl  = 0;
                m_act  = (!en_n && h >= 1) ? 1 : 0;
            end else begin
                if (m_pos < m_half) m_lvl = (m_lvl < m_peak) ? m_lvl + 1 : m_peak;
                else                m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
                m_pos++;
            end
        end
    end

    // Compare the outputs with the model, away from the active edge.
    always @(negedge clk) begin
        longint exp_ofs;
        bit     exp_ph;
        if (!done) begin
            exp_ofs = longint'(m_lvl) * longint'(m_step);
            exp_ph  = (m_act != 0) && (m_pos >= m_half);
            vectors++;
            if (longint'(offset) != exp_ofs || phase != exp_ph) begin
                errors++;
                $display("FAIL %s t=%0t offset=%0d phase=%0b expected offset=%0d phase=%0b",
                         tag, $time, offset, phase, exp_ofs, exp_ph);
            end
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired, actual=%0d cycles expected<=150000", cycles);
                done = 1'b1;
                $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic setp(input int p, input int a, input int s);
        period = 11'(p); amp = 11'(a); step = 13'(s);
    endtask

    initial begin
        // R1: reset state, and the first cycle after reset
        tag = "R1";
        setp(8, 10, 3);
        en_n = 1'b0;
        run(4);
        @(negedge clk); rst_n = 1'b1;
        run(1);
        // R5 R7 R10 R11: the limit is half the period (peak 6, half 4)
        tag = "R5 R7 R10 R11";
        run(40);
        // R6: the peak clips the level (half 8, peak 2)
        tag = "R6";
        setp(16, 10, 5);
        run(60);
        // R3: an odd period rounds down to even
        tag = "R3";
        setp(9, 100, 7);
        run(40);
        // R8: a change mid-period waits for the boundary
        tag = "R8";
        setp(12, 50, 2);
        run(17);
        setp(6, 4, 11);
        run(30);
        // R9: sync pulses restart the profile
        tag = "R9";
        setp(20, 30, 1);
        run(7);
        sync = 1'b1; run(3); sync = 1'b0; run(13);
        sync = 1'b1; run(1); sync = 1'b0; run(30);
        // R2: disable in the middle of a period
        tag = "R2";
        run(5);
        en_n = 1'b1; run(10);
        en_n = 1'b0; run(25);
        // R4: periods of 1 and 0 keep it idle
        tag = "R4";
        setp(1, 200, 9); run(20);
        setp(0, 200, 9); run(20);
        // R5 R6 R10: full-scale period, amplitude and step
        tag = "R5 R6 R10";
        setp(2047, 2047, 8191);
        run(4200);
        // R1: reset asserted again while running
        tag = "R1";
        rst_n = 1'b0; run(3);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule